// File: doc/BRIEF.md
# Capture-Compare Timer with PWM Output

This block is a free-running 32-bit up-counter with a small word-addressed register port. Software loads a start value, a reload value and a compare value. It then sets the run bit in the control word. The counter advances on every clock, or once every 2^(N+1) clocks when the divider is switched on. When it wraps past its all-ones value it either reloads or halts. A compare unit flags the cycle on which the count reaches the compare value. A capture unit snapshots the count when a chosen edge appears on an external input. In its paired mode, the capture unit stores two consecutive edges in two separate registers.

A single output pin is driven from the match and wrap events. Depending on the control word it either toggles on each trigger, or leaves its idle level for exactly one clock. Match, wrap and capture events latch into a sticky raw status word. An enable mask selects which of them reach the interrupt line. Software sets the mask with one register and clears it with another, writing ones in both cases.

Top module: `capture_compare_timer`

## Requirements
- R1: After reset every register reads zero, `pwm_out` is 0 and `irq` is 0.
- R2: With the run bit (control bit 0) set and the divider off, the count rises by one per clock. With the run bit clear, the count holds.
- R3: When the count wraps from all ones, it takes the reload value if control bit 1 is set. Otherwise it becomes 0 and the run bit clears, so counting stops. Each wrap sets status bit 1.
- R4: With control bit 5 set, the count advances once every 2^(N+1) clocks, where N is control bits 4:2.
- R5: With control bit 6 set, status bit 0 sets on the clock where the count becomes equal to the compare value. It sets only once for a single pass. With bit 6 clear it never sets.
- R6: Control bits 9:8 choose the capture edge on `cap_in`: 0 none, 1 rising, 2 falling, 3 either. A qualifying edge copies the count into capture register 1 and sets status bit 2. Edges that do not qualify change nothing.
- R7: With control bit 13 set, qualifying edges alternate between the two capture registers, first register 1 and then register 2. Status bit 2 sets only on the second edge of each pair.
- R8: With control bit 12 clear, the output rests at the level given by control bit 7. A trigger drives it to the opposite level for exactly one clock.
- R9: Control bits 11:10 select the trigger: 0 none, 1 wrap, 2 wrap or match. With control bit 12 set, each trigger inverts the output.
- R10: The raw status register at word 7 shows events whatever the mask. Word 8 shows raw status ANDed with the mask. Writing ones to word 8 clears those raw bits. `irq` is high exactly when a masked bit is set.
- R11: Writing ones to word 9 sets mask bits, and writing ones to word 10 clears them. Both words read back the mask.
- R12: A write to word 1 sets the count at the next edge. A write of any value to word 3 copies the reload value into the count at the next edge. Both writes take priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Word address: 0 control, 1 count, 2 reload, 3 trigger, 4 compare, 5 capture 1, 6 capture 2, 7 raw status, 8 masked status, 9 mask set, 10 mask clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| cap_in | input | 1 | Capture input, synchronous to `clk` |
| pwm_out | output | 1 | Trigger-driven output |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that `cap_in` is already synchronous to `clk` and held low through reset, so that no edge is seen on the first cycle. They also assume that software never issues a bus write and relies on a wrap or match in that same cycle, because such writes override the counter. The stimulus changes `cap_in` and every bus field only at falling clock edges. It keeps `cap_in` low during reset and changes control settings only through single-cycle writes.

// File: rtl/cct_pkg.sv
// Shared encodings for the capture-compare timer: register word addresses,
// control word layout and interrupt bit positions.
package cct_pkg;

    localparam int ADDR_W = 4;
    localparam int CTRL_W = 14;
    localparam int IRQ_N  = 3;

    // Interrupt bit positions (visible to software)
    localparam int IRQ_MATCH = 0;
    localparam int IRQ_WRAP  = 1;
    localparam int IRQ_CAPT  = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 4'd0,
        A_COUNT = 4'd1,
        A_LOAD  = 4'd2,
        A_TRIG  = 4'd3,
        A_MATCH = 4'd4,
        A_CAP1  = 4'd5,
        A_CAP2  = 4'd6,
        A_RAW   = 4'd7,
        A_STAT  = 4'd8,
        A_ENSET = 4'd9,
        A_ENCLR = 4'd10
    } reg_addr_e;

    // Control word, MSB first; bit positions are software-visible.
    typedef struct packed {
        logic       pair_mode;  // 13
        logic       toggle;     // 12
        logic [1:0] trig_mode;  // 11:10
        logic [1:0] edge_sel;   // 9:8
        logic       idle_high;  // 7
        logic       cmp_en;     // 6
        logic       div_en;     // 5
        logic [2:0] div_sel;    // 4:2
        logic       reload;     // 1
        logic       run;        // 0
    } ctrl_t;

endpackage

// File: rtl/cct_regs.sv
// Register file and interrupt logic. Holds control, reload, compare, mask and
// sticky raw status; decodes bus writes into strobes for the counter; returns
// read data combinationally. Assumes a single-cycle bus with no wait states.
module cct_regs
    import cct_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  cap1,
    input  logic [CNT_W-1:0]  cap2,
    input  logic [IRQ_N-1:0]  events,
    input  logic              auto_stop,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  match_val,
    output logic [IRQ_N-1:0]  irq_en,
    output logic [IRQ_N-1:0]  irq_raw,
    output logic              wr_count,
    output logic              wr_trig,
    output logic              irq
);

    logic             wr;
    logic             wr_ctrl, wr_load, wr_match, wr_stat, wr_set, wr_clr;
    logic [IRQ_N-1:0] clr_mask;
    logic [IRQ_N-1:0] irq_masked;

    // Write strobe decode
    always_comb begin
        wr       = bus_valid && bus_write;
        wr_ctrl  = wr && (bus_addr == A_CTRL);
        wr_count = wr && (bus_addr == A_COUNT);
        wr_load  = wr && (bus_addr == A_LOAD);
        wr_trig  = wr && (bus_addr == A_TRIG);
        wr_match = wr && (bus_addr == A_MATCH);
        wr_stat  = wr && (bus_addr == A_STAT);
        wr_set   = wr && (bus_addr == A_ENSET);
        wr_clr   = wr && (bus_addr == A_ENCLR);
        clr_mask = wr_stat ? bus_wdata[IRQ_N-1:0] : '0;
    end

    // Control word; a write wins over the hardware stop on wrap
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_ctrl)
            ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        else if (auto_stop)
            ctrl.run <= 1'b0;
    end

    // Reload and compare values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_val  <= '0;
            match_val <= '0;
        end else begin
            if (wr_load)  load_val  <= bus_wdata;
            if (wr_match) match_val <= bus_wdata;
        end
    end

    // Interrupt mask: set-ones and clear-ones ports
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_en <= '0;
        else if (wr_set)
            irq_en <= irq_en | bus_wdata[IRQ_N-1:0];
        else if (wr_clr)
            irq_en <= irq_en & ~bus_wdata[IRQ_N-1:0];
    end

    // Sticky raw status; a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_raw <= '0;
        else
            irq_raw <= (irq_raw & ~clr_mask) | events;
    end

    // Masked status and interrupt line
    always_comb begin
        irq_masked = irq_raw & irq_en;
        irq        = |irq_masked;
    end

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:          bus_rdata = CNT_W'(ctrl);
            A_COUNT:         bus_rdata = count;
            A_LOAD:          bus_rdata = load_val;
            A_MATCH:         bus_rdata = match_val;
            A_CAP1:          bus_rdata = cap1;
            A_CAP2:          bus_rdata = cap2;
            A_RAW:           bus_rdata = CNT_W'(irq_raw);
            A_STAT:          bus_rdata = CNT_W'(irq_masked);
            A_ENSET, A_ENCLR: bus_rdata = CNT_W'(irq_en);
            default:         bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cct_counter.sv
// Main counter with a power-of-two divider, wrap handling and compare.
// Bus writes to the count or trigger word override counting in that cycle,
// and suppress the wrap and match events that counting would have produced.
module cct_counter #(
    parameter int CNT_W = 32,
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             reload,
    input  logic             div_en,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             cmp_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] match_val,
    input  logic             wr_count,
    input  logic             wr_trig,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic             match_evt,
    output logic             wrap_evt,
    output logic             auto_stop
);

    localparam int PRE_W = 1 << DIV_W;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_lim;
    logic             tick;
    logic             at_max;
    logic             bus_owns;
    logic [CNT_W-1:0] nxt;

    // Advance enable, next value and events
    always_comb begin
        pre_lim   = (PRE_W'(2) << div_sel) - PRE_W'(1);
        tick      = run && (!div_en || (pre_cnt == pre_lim));
        at_max    = &count;
        bus_owns  = wr_count || wr_trig;
        nxt       = at_max ? (reload ? load_val : '0) : count + CNT_W'(1);
        wrap_evt  = tick && at_max && !bus_owns;
        match_evt = tick && cmp_en && (nxt == match_val) && !bus_owns;
        auto_stop = wrap_evt && !reload;
    end

    // Divider phase; restarts whenever the counter is idle or undivided
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !div_en)
            pre_cnt <= '0;
        else if (pre_cnt == pre_lim)
            pre_cnt <= '0;
        else
            pre_cnt <= pre_cnt + PRE_W'(1);
    end

    // Count register: direct write, then trigger reload, then counting
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (wr_count)
            count <= wdata;
        else if (wr_trig)
            count <= load_val;
        else if (tick)
            count <= nxt;
    end

endmodule

// File: rtl/cct_capture.sv
// Edge-selected capture of the count into one or two registers. Assumes
// cap_in is already synchronous to clk; one flop keeps its previous level.
module cct_capture #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_in,
    input  logic [1:0]       edge_sel,
    input  logic             pair_mode,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap1,
    output logic [CNT_W-1:0] cap2,
    output logic             cap_evt
);

    logic prev;
    logic phase;
    logic qual;

    // Qualify the current edge against the selected polarity
    always_comb begin
        case (edge_sel)
            2'd1:    qual = cap_in && !prev;
            2'd2:    qual = !cap_in && prev;
            2'd3:    qual = cap_in != prev;
            default: qual = 1'b0;
        endcase
        cap_evt = qual && (!pair_mode || phase);
    end

    // Previous input level
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= cap_in;
    end

    // Pair phase: 0 waits for the first edge, 1 for the second
    always_ff @(posedge clk) begin
        if (!rst_n || !pair_mode || edge_sel == 2'd0)
            phase <= 1'b0;
        else if (qual)
            phase <= !phase;
    end

    // Capture registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap1 <= '0;
            cap2 <= '0;
        end else if (qual) begin
            if (pair_mode && phase) cap2 <= count;
            else                    cap1 <= count;
        end
    end

endmodule

// File: rtl/cct_pwm.sv
// Output stage driven by wrap and match events, in pulse or toggle form.
// Trigger mode 3 is treated as no trigger.
module cct_pwm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] trig_mode,
    input  logic       toggle,
    input  logic       idle_high,
    input  logic       match_evt,
    input  logic       wrap_evt,
    output logic       pwm_out
);

    logic fire;

    // Trigger selection
    always_comb begin
        case (trig_mode)
            2'd1:    fire = wrap_evt;
            2'd2:    fire = wrap_evt || match_evt;
            default: fire = 1'b0;
        endcase
    end

    // Output level: invert or pulse on a trigger, otherwise rest or hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwm_out <= 1'b0;
        else if (fire)
            pwm_out <= toggle ? !pwm_out : !idle_high;
        else if (trig_mode == 2'd0 || !toggle)
            pwm_out <= idle_high;
    end

endmodule

// File: rtl/capture_compare_timer.sv
// Top of the capture-compare timer: ties the register file to the counter,
// capture and output stages. All logic runs on one clock with synchronous
// active-low reset.
module capture_compare_timer
    import cct_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DIV_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              cap_in,
    output logic              pwm_out,
    output logic              irq
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] count, load_val, match_val, cap1, cap2;
    logic [IRQ_N-1:0] irq_en, irq_raw, events;
    logic             match_evt, wrap_evt, cap_evt, auto_stop;
    logic             wr_count, wr_trig;

    // Event vector in interrupt bit order
    always_comb begin
        events            = '0;
        events[IRQ_MATCH] = match_evt;
        events[IRQ_WRAP]  = wrap_evt;
        events[IRQ_CAPT]  = cap_evt;
    end

    cct_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count), .cap1(cap1), .cap2(cap2),
        .events(events), .auto_stop(auto_stop),
        .ctrl(ctrl), .load_val(load_val), .match_val(match_val),
        .irq_en(irq_en), .irq_raw(irq_raw),
        .wr_count(wr_count), .wr_trig(wr_trig), .irq(irq)
    );

    cct_counter #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .run(ctrl.run), .reload(ctrl.reload),
        .div_en(ctrl.div_en), .div_sel(DIV_W'(ctrl.div_sel)),
        .cmp_en(ctrl.cmp_en),
        .load_val(load_val), .match_val(match_val),
        .wr_count(wr_count), .wr_trig(wr_trig), .wdata(bus_wdata),
        .count(count), .match_evt(match_evt), .wrap_evt(wrap_evt),
        .auto_stop(auto_stop)
    );

    cct_capture #(.CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in),
        .edge_sel(ctrl.edge_sel), .pair_mode(ctrl.pair_mode),
        .count(count), .cap1(cap1), .cap2(cap2), .cap_evt(cap_evt)
    );

    cct_pwm u_pwm (
        .clk(clk), .rst_n(rst_n),
        .trig_mode(ctrl.trig_mode), .toggle(ctrl.toggle),
        .idle_high(ctrl.idle_high),
        .match_evt(match_evt), .wrap_evt(wrap_evt), .pwm_out(pwm_out)
    );

endmodule

// File: rtl/cct_checker.sv
// Temporal properties of the timer, attached to the top by bind.
module cct_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             reload,
    input logic             cmp_en,
    input logic             toggle,
    input logic [1:0]       trig_mode,
    input logic             idle_high,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] load_val,
    input logic             wrap_evt,
    input logic             match_evt,
    input logic             cap_evt,
    input logic [2:0]       irq_raw,
    input logic [2:0]       irq_en,
    input logic             irq,
    input logic             pwm_out,
    input logic             wr_count,
    input logic             wr_trig
);

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_count && !wr_trig) |=> $stable(count));

    // R3
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_evt && reload) |=> count == $past(load_val));

    // R3
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_evt && !reload) |=> count == '0);

    // R3
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> irq_raw[1]);

    // R5
    match_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |-> cmp_en);

    // R5
    match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> irq_raw[0]);

    // R7
    capture_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> irq_raw[2]);

    // R8
    pulse_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((trig_mode == 2'd0 || !toggle) && !wrap_evt && !match_evt)
        |=> pwm_out == $past(idle_high));

    // R10
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 3'b000) |-> !irq);

endmodule

bind capture_compare_timer cct_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .run(ctrl.run), .reload(ctrl.reload), .cmp_en(ctrl.cmp_en),
    .toggle(ctrl.toggle), .trig_mode(ctrl.trig_mode), .idle_high(ctrl.idle_high),
    .count(count), .load_val(load_val),
    .wrap_evt(wrap_evt), .match_evt(match_evt), .cap_evt(cap_evt),
    .irq_raw(irq_raw), .irq_en(irq_en), .irq(irq), .pwm_out(pwm_out),
    .wr_count(wr_count), .wr_trig(wr_trig)
);

// File: tb/tb_capture_compare_timer.sv
`timescale 1ns/1ps
module tb_capture_compare_timer;
    import cct_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cap_in = 1'b0;
    logic        pwm_out, irq;
    int          nchk = 0, nerr = 0;
    logic [31:0] d;

    capture_compare_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_in(cap_in), .pwm_out(pwm_out), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // Counting table: control word, start count, clocks to wait, expected count
    localparam int NV = 6;
    localparam logic [31:0] V_CTRL [NV] = '{32'h01, 32'h21, 32'h25, 32'h29, 32'h00, 32'h3D};
    localparam logic [31:0] V_INIT [NV] = '{32'd10, 32'd100, 32'd0, 32'd0, 32'd7, 32'd0};
    localparam int          V_CYC  [NV] = '{5, 8, 8, 16, 5, 300};
    localparam logic [31:0] V_EXP  [NV] = '{32'd15, 32'd104, 32'd2, 32'd2, 32'd7, 32'd1};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; spans exactly one rising edge
    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_valid = 1'b0; bus_write = 1'b0; bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, d);  check("R1 ctrl", d, 0);
        rd(A_COUNT, d); check("R1 count", d, 0);
        rd(A_RAW, d);   check("R1 raw", d, 0);
        rd(A_ENSET, d); check("R1 mask", d, 0);
        rd(A_CAP1, d);  check("R1 cap1", d, 0);
        check("R1 pwm", {31'd0, pwm_out}, 0);
        check("R1 irq", {31'd0, irq}, 0);

        // R2 R4 counting table
        for (int i = 0; i < NV; i++) begin
            wr(A_CTRL, 0);
            wr(A_COUNT, V_INIT[i]);
            wr(A_CTRL, V_CTRL[i]);
            step(V_CYC[i]);
            rd(A_COUNT, d);
            check($sformatf("R2/R4 row %0d", i), d, V_EXP[i]);
        end

        // R3 wrap with reload
        wr(A_CTRL, 0); wr(A_STAT, 7);
        wr(A_COUNT, 32'hFFFF_FFFE); wr(A_LOAD, 32'h100); wr(A_CTRL, 32'h3);
        step(1); rd(A_COUNT, d); check("R3 at max", d, 32'hFFFF_FFFF);
        step(1); rd(A_COUNT, d); check("R3 reload", d, 32'h100);
        rd(A_RAW, d); check("R3 wrap flag", d, 2);

        // R3 wrap without reload stops
        wr(A_CTRL, 0); wr(A_STAT, 7);
        wr(A_COUNT, 32'hFFFF_FFFF); wr(A_CTRL, 32'h1);
        step(4); rd(A_COUNT, d); check("R3 stop count", d, 0);
        rd(A_CTRL, d); check("R3 run cleared", d, 0);

        // R5 compare
        wr(A_STAT, 7);
        wr(A_COUNT, 32'h20); wr(A_MATCH, 32'h23); wr(A_CTRL, 32'h41);
        step(2); rd(A_RAW, d); check("R5 before match", d, 0);
        step(1); rd(A_RAW, d); check("R5 on match", d, 1);
        wr(A_STAT, 1); step(3); rd(A_RAW, d); check("R5 once", d, 0);
        wr(A_CTRL, 0); wr(A_COUNT, 32'h20); wr(A_CTRL, 32'h01);
        step(5); rd(A_RAW, d); check("R5 compare off", d, 0);

        // R12 count write and trigger reload
        wr(A_CTRL, 0); wr(A_LOAD, 32'hABC); wr(A_COUNT, 5);
        rd(A_COUNT, d); check("R12 count write", d, 5);
        wr(A_CTRL, 1);
        wr(A_TRIG, 32'h1234);
        rd(A_COUNT, d); check("R12 trigger reload", d, 32'hABC);
        step(2); rd(A_COUNT, d); check("R12 resumes", d, 32'hABE);

        // R6 edge selection, counter stopped
        wr(A_CTRL, 0); wr(A_COUNT, 32'h55); wr(A_STAT, 7); wr(A_CTRL, 32'h100);
        cap_in = 1'b1; step(1);
        rd(A_CAP1, d); check("R6 rising capture", d, 32'h55);
        rd(A_RAW, d);  check("R6 capture flag", d, 4);
        wr(A_COUNT, 32'h66); wr(A_STAT, 4);
        cap_in = 1'b0; step(1);
        rd(A_CAP1, d); check("R6 falling ignored", d, 32'h55);
        rd(A_RAW, d);  check("R6 no flag", d, 0);
        wr(A_CTRL, 32'h300);
        cap_in = 1'b1; step(1);
        rd(A_CAP1, d); check("R6 either edge", d, 32'h66);
        wr(A_CTRL, 0); wr(A_COUNT, 32'h77);
        cap_in = 1'b0; step(1);
        rd(A_CAP1, d); check("R6 edge none", d, 32'h66);
        wr(A_CTRL, 32'h200);
        cap_in = 1'b1; step(1);
        rd(A_CAP1, d); check("R6 rise ignored in fall mode", d, 32'h66);
        cap_in = 1'b0; step(1);
        rd(A_CAP1, d); check("R6 falling capture", d, 32'h77);

        // R6 capture of a running count
        wr(A_COUNT, 32'h1000); wr(A_CTRL, 32'h101);
        step(3);
        cap_in = 1'b1; step(1);
        rd(A_CAP1, d); check("R6 running capture", d, 32'h1003);

        // R7 paired capture
        wr(A_CTRL, 0); cap_in = 1'b0; step(1);
        wr(A_COUNT, 32'h11); wr(A_STAT, 7); wr(A_CTRL, 32'h2100);
        cap_in = 1'b1; step(1);
        rd(A_CAP1, d); check("R7 first edge", d, 32'h11);
        rd(A_RAW, d);  check("R7 no flag on first", d, 0);
        cap_in = 1'b0; step(1);
        wr(A_COUNT, 32'h22);
        cap_in = 1'b1; step(1);
        rd(A_CAP2, d); check("R7 second edge", d, 32'h22);
        rd(A_CAP1, d); check("R7 first kept", d, 32'h11);
        rd(A_RAW, d);  check("R7 flag on second", d, 4);
        cap_in = 1'b0;

        // R8 pulse mode, idle low
        wr(A_CTRL, 0); wr(A_COUNT, 32'hFFFF_FFFE); wr(A_LOAD, 0); wr(A_CTRL, 32'h403);
        step(1); check("R8 idle low", {31'd0, pwm_out}, 0);
        step(1); check("R8 pulse", {31'd0, pwm_out}, 1);
        step(1); check("R8 pulse ends", {31'd0, pwm_out}, 0);
        // R8 pulse mode, idle high
        wr(A_CTRL, 32'h80); wr(A_COUNT, 32'hFFFF_FFFE);
        check("R8 idle high", {31'd0, pwm_out}, 1);
        wr(A_CTRL, 32'h483);
        step(2); check("R8 low pulse", {31'd0, pwm_out}, 0);
        step(1); check("R8 back high", {31'd0, pwm_out}, 1);

        // R9 toggle on wrap and match
        wr(A_CTRL, 0); wr(A_COUNT, 0); wr(A_MATCH, 2);
        wr(A_COUNT, 32'hFFFF_FFFE); wr(A_CTRL, 32'h1843);
        step(1); check("R9 before wrap", {31'd0, pwm_out}, 0);
        step(1); check("R9 toggle on wrap", {31'd0, pwm_out}, 1);
        step(2); check("R9 toggle on match", {31'd0, pwm_out}, 0);
        step(1); check("R9 holds", {31'd0, pwm_out}, 0);
        // R9 wrap-only mode ignores match
        wr(A_CTRL, 0); wr(A_COUNT, 0); wr(A_CTRL, 32'h1441);
        step(4); check("R9 match ignored", {31'd0, pwm_out}, 0);

        // R10 R11 status and mask
        wr(A_CTRL, 0); wr(A_STAT, 7); wr(A_ENCLR, 7);
        wr(A_COUNT, 32'hFFFF_FFFF); wr(A_CTRL, 32'h1);
        step(1);
        rd(A_RAW, d);  check("R10 raw unmasked", d, 2);
        rd(A_STAT, d); check("R10 masked hidden", d, 0);
        check("R10 irq low", {31'd0, irq}, 0);
        wr(A_ENSET, 2);
        rd(A_ENCLR, d); check("R11 mask via clear word", d, 2);
        rd(A_STAT, d);  check("R10 masked shown", d, 2);
        check("R10 irq high", {31'd0, irq}, 1);
        wr(A_ENSET, 1);
        rd(A_ENSET, d); check("R11 set ORs", d, 3);
        wr(A_ENCLR, 2);
        rd(A_ENSET, d); check("R11 clear", d, 1);
        check("R10 irq masked off", {31'd0, irq}, 0);
        rd(A_RAW, d);  check("R10 raw kept", d, 2);
        wr(A_ENSET, 2); wr(A_STAT, 1);
        rd(A_RAW, d);  check("R10 clear other bit only", d, 2);
        wr(A_STAT, 2);
        rd(A_RAW, d);  check("R10 cleared", d, 0);
        check("R10 irq cleared", {31'd0, irq}, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule